// File: doc/BRIEF.md
# Fault address capture register bank

This block keeps a record of the most recent unserviced faults for two fault classes: memory-protection faults and bus faults. A fault-report interface gives, for each event, the class, the address the instruction asked for, the address of the aligned piece that actually failed, and a small set of cause flags. Each class has a 32-bit address register that is loaded only by fault events. Each class also has a valid flag and sticky cause bits in a shared status register. A one-bit hard-fault status register records whether the stacked return address points at the preempted instruction.

Software uses a simple register port to read the bank and to clear status bits by writing ones. Every access has its size and alignment checked against the rules for the register it targets. An access that breaks those rules gets an error response, reads back zero and changes no state. Each request is answered exactly one cycle later.

Top module: `fltcap_regbank`

## Requirements
- R1: On a memory-protection fault (class 0), the captured address is the failing-piece address, not the requested address.
- R2: On a bus fault (class 1), the captured address is the requested address, even when a different piece failed.
- R3: The status register is at offset 0x00. Memory-protection cause flags are in bits [3:0] and its valid flag is bit 7. Bus cause flags are in bits [11:8] and its valid flag is bit 15. The address registers are at 0x14 (memory-protection) and 0x18 (bus). After reset, every register reads zero.
- R4: Status bits are sticky. A fault event ORs its cause flags into the status register and sets its valid flag. Writing 1 to a bit clears it, and writing 0 has no effect. An event and a clear that hit the same bit in the same cycle leave the bit set.
- R5: While a class's valid flag is 1, a new fault of that class leaves that class's address register unchanged.
- R6: The status register and the priority registers (0x04, 0x08, 0x0C) accept byte, halfword and word accesses on natural alignment. Byte lane n is data bits [8n+7:8n], and offset bits [1:0] select the lane. A read returns only the addressed lanes, with all other bits zero.
- R7: The hard-fault status register (0x10) and both address registers accept only aligned word accesses.
- R8: The size field encodes 0 as byte, 1 as halfword, 2 as word; 3 is illegal. Any of the following gets an error response with read data zero and modifies no state: an illegal size, a misaligned access, a disallowed width, or an unmapped offset.
- R9: A write to an address register gets no error but does not change its content.
- R10: Hard-fault status bit 0 is set by a hard-fault event and clears only on reset or when software writes 1 to it.
- R11: Every request gets exactly one response, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_class | input | 1 | 0 memory-protection, 1 bus |
| flt_req_addr | input | ADDR_W | Address requested by the instruction |
| flt_part_addr | input | ADDR_W | Address of the aligned piece that failed |
| flt_cause | input | CAUSE_W | Cause flags of the event |
| hf_evt | input | 1 | Hard-fault event, return address points at preempted instruction |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_off | input | OFF_W | Byte offset into the bank |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, lane aligned |
| bus_rsp_valid | output | 1 | Response strobe |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Error response |

## Verification
The bench builds the block with its default parameters: four cause flags, three priority registers and a five-bit offset. With these defaults the register offsets named in the requirements apply directly. It also leaves one word slot unmapped (0x1C), so the unmapped-offset error path can be reached. The scenarios cover split unaligned faults of both classes and repeated faults while a valid flag is set. They also cover byte and halfword write-1-clear on the status register, and a hard-fault event that coincides with its clear.

// File: rtl/fltcap_pkg.sv
package fltcap_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} acc_size_e;

    typedef enum logic [2:0] {
        REG_NONE, REG_STATUS, REG_PRIO, REG_HARD, REG_PADDR, REG_BADDR
    } reg_id_e;

    typedef struct packed {
        reg_id_e    id;
        logic [7:0] widx;
        logic       legal;
        logic [3:0] lanes;
    } access_t;

    function automatic logic [3:0] lane_sel(input acc_size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_BYTE: lane_sel = 4'b0001 << lo;
            SZ_HALF: lane_sel = lo[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: lane_sel = 4'b1111;
            default: lane_sel = 4'b0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_bits(input logic [3:0] ln);
        for (int i = 0; i < 4; i++) lane_bits[8*i +: 8] = {8{ln[i]}};
    endfunction
endpackage

// File: rtl/fltcap_decode.sv
module fltcap_decode
    import fltcap_pkg::*;
#(
    parameter int OFF_W    = 5,
    parameter int NUM_PRIO = 3
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    output access_t          acc
);
    localparam int WI_W = OFF_W - 2;
    localparam logic [WI_W-1:0] W_HARD  = WI_W'(NUM_PRIO + 1);
    localparam logic [WI_W-1:0] W_PADDR = WI_W'(NUM_PRIO + 2);
    localparam logic [WI_W-1:0] W_BADDR = WI_W'(NUM_PRIO + 3);

    logic [WI_W-1:0] widx;
    logic            aligned;
    logic            flexible;
    acc_size_e       sz;

    assign widx = off[OFF_W-1:2];
    assign sz   = acc_size_e'(size);

    always_comb begin
        acc      = '0;
        acc.id   = REG_NONE;
        acc.widx = 8'(widx);
        if (widx == '0)                       acc.id = REG_STATUS;
        else if (32'(widx) <= NUM_PRIO)        acc.id = REG_PRIO;
        else if (widx == W_HARD)               acc.id = REG_HARD;
        else if (widx == W_PADDR)              acc.id = REG_PADDR;
        else if (widx == W_BADDR)              acc.id = REG_BADDR;
        case (sz)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = !off[0];
            SZ_WORD: aligned = (off[1:0] == 2'b00);
            default: aligned = 1'b0;
        endcase
        flexible  = (acc.id == REG_STATUS) || (acc.id == REG_PRIO);
        acc.legal = (acc.id != REG_NONE) && aligned && (flexible || sz == SZ_WORD);
        acc.lanes = acc.legal ? lane_sel(sz, off[1:0]) : 4'b0000;
    end
endmodule

// File: rtl/fltcap_slot.sv
module fltcap_slot #(
    parameter int ADDR_W  = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt,
    input  logic [ADDR_W-1:0]  cap_addr,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [CAUSE_W-1:0] clr_cause,
    input  logic               clr_valid,
    output logic [ADDR_W-1:0]  addr_q,
    output logic               valid_q,
    output logic [CAUSE_W-1:0] cause_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
            cause_q <= '0;
        end else begin
            if (evt && !valid_q) addr_q <= cap_addr;
            valid_q <= evt | (valid_q & ~clr_valid);
            cause_q <= (cause_q & ~clr_cause) | (evt ? cause : '0);
        end
    end
endmodule

// File: rtl/fltcap_regbank.sv
module fltcap_regbank
    import fltcap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CAUSE_W  = 4,
    parameter int OFF_W    = 5,
    parameter int NUM_PRIO = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flt_valid,
    input  logic               flt_class,
    input  logic [ADDR_W-1:0]  flt_req_addr,
    input  logic [ADDR_W-1:0]  flt_part_addr,
    input  logic [CAUSE_W-1:0] flt_cause,
    input  logic               hf_evt,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [OFF_W-1:0]   bus_off,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic               bus_rsp_valid,
    output logic [31:0]        bus_rdata,
    output logic               bus_err
);
    localparam int NCLS      = 2;
    localparam int FIELD_W   = 8;
    localparam int VALID_BIT = FIELD_W - 1;

    access_t            acc;
    logic               wr;
    logic [31:0]        bmask;
    logic [31:0]        wm;
    logic [ADDR_W-1:0]  slot_addr  [NCLS];
    logic               slot_valid [NCLS];
    logic [CAUSE_W-1:0] slot_cause [NCLS];
    logic [31:0]        prio_q     [NUM_PRIO];
    logic [31:0]        status_word;
    logic               hard_q;
    logic               hard_clr;
    logic [31:0]        rd_word;
    logic               prot_vld, bus_vld;
    logic [ADDR_W-1:0]  prot_adr, bus_adr;

    fltcap_decode #(.OFF_W(OFF_W), .NUM_PRIO(NUM_PRIO)) u_dec (
        .off(bus_off), .size(bus_size), .acc(acc)
    );

    assign wr    = bus_req && bus_we && acc.legal;
    assign bmask = lane_bits(acc.lanes);
    assign wm    = bus_wdata & bmask;

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        logic               evt;
        logic [ADDR_W-1:0]  pick;
        logic               st_wr;
        assign evt   = flt_valid && (flt_class == 1'(g));
        assign st_wr = wr && (acc.id == REG_STATUS);
        if (g == 0) begin : g_part
            assign pick = flt_part_addr;
        end else begin : g_req
            assign pick = flt_req_addr;
        end
        fltcap_slot #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_slot (
            .clk(clk), .rst(rst), .evt(evt), .cap_addr(pick), .cause(flt_cause),
            .clr_cause(st_wr ? wm[g*FIELD_W +: CAUSE_W] : '0),
            .clr_valid(st_wr && wm[g*FIELD_W + VALID_BIT]),
            .addr_q(slot_addr[g]), .valid_q(slot_valid[g]), .cause_q(slot_cause[g])
        );
    end

    for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) prio_q[p] <= '0;
            else if (wr && acc.id == REG_PRIO && 32'(acc.widx) == p + 1)
                prio_q[p] <= (prio_q[p] & ~bmask) | wm;
        end
    end

    assign hard_clr = wr && (acc.id == REG_HARD) && wm[0];
    always_ff @(posedge clk) begin
        if (rst) hard_q <= 1'b0;
        else     hard_q <= hf_evt | (hard_q & ~hard_clr);
    end

    always_comb begin
        status_word = '0;
        for (int c = 0; c < NCLS; c++) begin
            status_word[c*FIELD_W +: CAUSE_W]     = slot_cause[c];
            status_word[c*FIELD_W + VALID_BIT]    = slot_valid[c];
        end
    end

    always_comb begin
        rd_word = '0;
        case (acc.id)
            REG_STATUS: rd_word = status_word;
            REG_PRIO: begin
                for (int p = 0; p < NUM_PRIO; p++)
                    if (32'(acc.widx) == p + 1) rd_word = prio_q[p];
            end
            REG_HARD:  rd_word = {31'd0, hard_q};
            REG_PADDR: rd_word = 32'(slot_addr[0]);
            REG_BADDR: rd_word = 32'(slot_addr[1]);
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rsp_valid <= 1'b0;
            bus_rdata     <= '0;
            bus_err       <= 1'b0;
        end else begin
            bus_rsp_valid <= bus_req;
            bus_err       <= bus_req && !acc.legal;
            bus_rdata     <= (bus_req && !bus_we && acc.legal) ? (rd_word & bmask) : '0;
        end
    end

    assign prot_vld = slot_valid[0];
    assign bus_vld  = slot_valid[1];
    assign prot_adr = slot_addr[0];
    assign bus_adr  = slot_addr[1];
endmodule

// File: rtl/fltcap_regbank_chk.sv
module fltcap_regbank_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              flt_valid,
    input logic              flt_class,
    input logic [ADDR_W-1:0] flt_req_addr,
    input logic [ADDR_W-1:0] flt_part_addr,
    input logic              hf_evt,
    input logic              bus_req,
    input logic              bus_rsp_valid,
    input logic              bus_err,
    input logic [31:0]       bus_rdata,
    input logic              prot_vld,
    input logic              bus_vld,
    input logic [ADDR_W-1:0] prot_adr,
    input logic [ADDR_W-1:0] bus_adr,
    input logic              hard_q,
    input logic              hard_clr
);
    AST_PROT_PART_ADDR: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_vld) |-> (prot_adr == $past(flt_part_addr) && $past(flt_valid && !flt_class))); // R1
    AST_BUS_REQ_ADDR: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_vld) |-> (bus_adr == $past(flt_req_addr) && $past(flt_valid && flt_class))); // R2
    AST_PROT_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        prot_vld |=> $stable(prot_adr)); // R5
    AST_BUS_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        bus_vld |=> $stable(bus_adr)); // R5
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_rsp_valid && bus_err) |-> (bus_rdata == 32'd0)); // R8
    AST_HARD_CLEAR_ONLY_W1C: assert property (@(posedge clk) disable iff (rst)
        $fell(hard_q) |-> $past(hard_clr && !hf_evt)); // R10
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_rsp_valid); // R11
    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rsp_valid) |-> $past(bus_req)); // R11
endmodule

bind fltcap_regbank fltcap_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_class(flt_class),
    .flt_req_addr(flt_req_addr), .flt_part_addr(flt_part_addr), .hf_evt(hf_evt),
    .bus_req(bus_req), .bus_rsp_valid(bus_rsp_valid), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .prot_vld(prot_vld), .bus_vld(bus_vld),
    .prot_adr(prot_adr), .bus_adr(bus_adr), .hard_q(hard_q), .hard_clr(hard_clr)
);

// File: tb/fltcap_regbank_bench.sv
module fltcap_regbank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flt_valid = 1'b0, flt_class = 1'b0;
    logic [31:0] flt_req_addr = '0, flt_part_addr = '0;
    logic [3:0]  flt_cause = '0;
    logic        hf_evt = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_off = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rsp_valid, bus_err;
    logic [31:0] bus_rdata;

    int checks = 0, errors = 0;
    logic [31:0] exp_d[$];
    logic        exp_e[$];
    string       exp_t[$];

    always #2.5 clk = ~clk;

    fltcap_regbank u_fltcap_regbank (
        .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_class(flt_class),
        .flt_req_addr(flt_req_addr), .flt_part_addr(flt_part_addr), .flt_cause(flt_cause),
        .hf_evt(hf_evt), .bus_req(bus_req), .bus_we(bus_we), .bus_off(bus_off),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    // monitor: pops the expected response for every response seen
    always @(negedge clk) begin
        if (!rst && bus_rsp_valid) begin
            if (exp_d.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected response: actual rsp_valid=1 expected 0");
            end else begin
                logic [31:0] d; logic e; string t;
                d = exp_d.pop_front(); e = exp_e.pop_front(); t = exp_t.pop_front();
                checks++;
                if (bus_rdata !== d || bus_err !== e) begin
                    errors++;
                    $display("FAIL %s: actual data=%h err=%b expected data=%h err=%b",
                             t, bus_rdata, bus_err, d, e);
                end
            end
        end
    end

    task automatic push(input logic [31:0] d, input logic e, input string t);
        exp_d.push_back(d); exp_e.push_back(e); exp_t.push_back(t);
    endtask

    task automatic acc(input logic we, input logic [4:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] ed, input logic ee,
                       input string t);
        @(negedge clk);
        push(ed, ee, t);
        bus_req = 1'b1; bus_we = we; bus_off = off; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] off, input logic [31:0] ed, input string t);
        acc(1'b0, off, 2'd2, 32'd0, ed, 1'b0, t);
    endtask

    task automatic wr(input logic [4:0] off, input logic [1:0] sz, input logic [31:0] wd,
                      input string t);
        acc(1'b1, off, sz, wd, 32'd0, 1'b0, t);
    endtask

    task automatic fault(input logic cls, input logic [31:0] ra, input logic [31:0] pa,
                         input logic [3:0] c);
        @(negedge clk);
        flt_valid = 1'b1; flt_class = cls; flt_req_addr = ra; flt_part_addr = pa; flt_cause = c;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // reset state
        rd(5'h00, 32'h0, "R3 status after reset");
        rd(5'h14, 32'h0, "R3 prot addr after reset");
        rd(5'h18, 32'h0, "R3 bus addr after reset");
        rd(5'h10, 32'h0, "R3 hard status after reset");
        rd(5'h08, 32'h0, "R3 prio after reset");
        // split unaligned faults
        fault(1'b0, 32'h1003, 32'h1004, 4'h2);
        rd(5'h14, 32'h1004, "R1 prot captures failing piece");
        rd(5'h00, 32'h82, "R3 prot valid and cause");
        fault(1'b1, 32'h2001, 32'h2004, 4'h1);
        rd(5'h18, 32'h2001, "R2 bus captures requested address");
        rd(5'h00, 32'h8182, "R3 both classes in status");
        // repeat faults while valid
        fault(1'b0, 32'h2FFE, 32'h3000, 4'h4);
        rd(5'h14, 32'h1004, "R5 first prot address kept");
        rd(5'h00, 32'h8186, "R4 causes accumulate");
        fault(1'b1, 32'h4444, 32'h4448, 4'h1);
        rd(5'h18, 32'h2001, "R5 first bus address kept");
        // write-1-clear behaviour
        wr(5'h00, 2'd2, 32'h0, "R4 write zero");
        rd(5'h00, 32'h8186, "R4 write zero has no effect");
        wr(5'h00, 2'd0, 32'h80, "R6 byte w1c");
        rd(5'h00, 32'h8106, "R6 byte write clears prot valid");
        rd(5'h14, 32'h1004, "R9 addr kept after valid clear");
        fault(1'b0, 32'h5007, 32'h5008, 4'h0);
        rd(5'h14, 32'h5008, "R1 reload after clear");
        rd(5'h00, 32'h8186, "R4 valid set again");
        wr(5'h00, 2'd1, 32'h0100, "R6 half w1c");
        rd(5'h00, 32'h8086, "R6 half write clears bus cause bit");
        acc(1'b0, 5'h01, 2'd0, 32'h0, 32'h8000, 1'b0, "R6 byte read lane 1");
        // illegal accesses
        acc(1'b1, 5'h01, 2'd1, 32'hFFFFFFFF, 32'h0, 1'b1, "R8 misaligned half");
        rd(5'h00, 32'h8086, "R8 misaligned write left status");
        acc(1'b0, 5'h14, 2'd0, 32'h0, 32'h0, 1'b1, "R7 byte read of addr reg");
        acc(1'b1, 5'h10, 2'd1, 32'h0, 32'h0, 1'b1, "R7 half write of hard reg");
        acc(1'b0, 5'h00, 2'd3, 32'h0, 32'h0, 1'b1, "R8 size code 3");
        acc(1'b0, 5'h1C, 2'd2, 32'h0, 32'h0, 1'b1, "R8 unmapped offset");
        acc(1'b1, 5'h02, 2'd2, 32'hFFFFFFFF, 32'h0, 1'b1, "R8 misaligned word");
        rd(5'h00, 32'h8086, "R8 status untouched");
        // address registers ignore writes
        wr(5'h14, 2'd2, 32'hDEAD, "R9 write prot addr");
        rd(5'h14, 32'h5008, "R9 prot addr unchanged");
        // priority registers
        wr(5'h0A, 2'd0, 32'h005A0000, "R6 prio byte write");
        rd(5'h08, 32'h005A0000, "R6 prio byte lane placed");
        wr(5'h0C, 2'd2, 32'h11223344, "R6 prio word write");
        rd(5'h0C, 32'h11223344, "R6 prio word read");
        acc(1'b0, 5'h0E, 2'd1, 32'h0, 32'h11220000, 1'b0, "R6 prio half read");
        // hard-fault sticky bit
        @(negedge clk) hf_evt = 1'b1;
        @(negedge clk) hf_evt = 1'b0;
        rd(5'h10, 32'h1, "R10 hard bit set");
        wr(5'h10, 2'd2, 32'h0, "R10 write zero");
        rd(5'h10, 32'h1, "R10 write zero no effect");
        @(negedge clk);
        push(32'h0, 1'b0, "R4 simultaneous write");
        hf_evt = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_off = 5'h10;
        bus_size = 2'd2; bus_wdata = 32'h1;
        @(negedge clk);
        hf_evt = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        rd(5'h10, 32'h1, "R4 event beats clear");
        wr(5'h10, 2'd2, 32'h1, "R10 w1c");
        rd(5'h10, 32'h0, "R10 hard bit cleared");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_d.size() != 0) begin
            errors++;
            $display("FAIL R11 missing responses: actual=%0d pending expected=0", exp_d.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule